// File: doc/BRIEF.md
# Periodic Source Health Monitor

This block watches a single data source that is supposed to deliver one item per period of `PERIOD` clock cycles, each item landing within `JITTER` cycles either side of its nominal instant. The source marks an item by raising `data_strobe` for one cycle. The monitor times the gaps between items and reports what it sees. Each output pulse lasts one cycle.

While the source is healthy, the monitor is tolerant. A gap long enough to mean one item went missing gives a `miss_pulse`. After `MISS_LIMIT` such gaps in a row, it gives `err_pulse` in place of a miss and raises `in_error`. While in error, the monitor is strict. It emits no misses. It counts items that arrive back to back with correct spacing, and any badly spaced item restarts that count. Once `RECOVER_COUNT` items in a row are well spaced, it gives `ok_pulse` and drops `in_error`. All four parameters are fixed at elaboration. A configuration with `2*JITTER >= PERIOD`, or with a zero miss limit or recovery count, stops elaboration.

Top module: `periodic_source_monitor`

## Requirements
- R1: Synchronous reset clears all three pulses and `in_error`. The gap timer counts from the last clock edge on which `rst` is high, so with a silent source the first miss appears on exactly the `PERIOD+2*JITTER`-th edge after that edge.
- R2: While healthy and silent, a miss is reported `PERIOD+2*JITTER` edges after the last item, and again every `PERIOD` edges after that. Each miss shows as `miss_pulse` in the cycle after that edge.
- R3: An item clears the count of missing items and re-arms the first deadline. An item that arrives on the very edge of a deadline counts as an item, so no miss is reported for that edge.
- R4: The missing item that completes `MISS_LIMIT` in a row, falling `MISS_LIMIT*PERIOD+2*JITTER` edges after the last item, raises `err_pulse` and not `miss_pulse`. `in_error` rises in the same cycle.
- R5: No `miss_pulse` occurs while `in_error` is high, however long the source stays silent.
- R6: While in error, when `RECOVER_COUNT` items arrive in a row with each spacing strictly greater than `PERIOD-JITTER` and strictly less than `PERIOD+JITTER` edges, `ok_pulse` is raised and `in_error` falls in the same cycle, right after the edge of the last of those items. The first item seen in error counts as one.
- R7: While in error, an item whose spacing from the previous item is `PERIOD-JITTER` or less, or `PERIOD+JITTER` or more, resets the run of good items to one. This includes both exact boundary values.
- R8: Every pulse is registered and is high for exactly one cycle. `err_pulse` follows an edge with no item, `ok_pulse` follows an item edge, and `miss_pulse` and `err_pulse` never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_strobe | input | 1 | One-cycle marker of an arriving item |
| err_pulse | output | 1 | Source declared faulty |
| ok_pulse | output | 1 | Source declared recovered |
| miss_pulse | output | 1 | One item missing while healthy |
| in_error | output | 1 | High while the source is considered faulty |

## Verification
All results are registered on the edge that decides them. A miss or error appears in the cycle after the deadline edge, and an ok appears in the cycle after the item edge that completes recovery. `in_error` changes together with the err or ok pulse. The bench drives the strobe and samples every output 1 ns after each rising edge. Edges are counted from the previous item, or from the last reset edge, so every expected pulse is tied to one exact edge. Each vector sums the pulses over its whole gap, so a pulse that is one edge early or late still lands in the right gap. The exact edge is pinned by directed checks that sample the cycles on either side of the first miss and of the error.

// File: rtl/psm_pkg.sv
package psm_pkg;

    typedef enum logic {
        MODE_HEALTHY = 1'b0,
        MODE_FAULT   = 1'b1
    } mode_e;

    typedef struct packed {
        logic miss;
        logic err;
        logic ok;
    } pulse_t;

    // Legal configuration: jitter window narrower than half a period,
    // non-zero limits.
    function automatic bit cfg_legal(input int period, input int jitter,
                                     input int miss_limit, input int rec_count);
        return (period > 0) && (jitter >= 0) && (2 * jitter < period)
            && (miss_limit > 0) && (rec_count > 0);
    endfunction

    // Bits needed to hold the longest gap the healthy mode ever measures.
    function automatic int gap_bits(input int period, input int jitter,
                                    input int miss_limit);
        return $clog2((miss_limit + 1) * period + 2 * jitter + 2);
    endfunction

endpackage

// File: rtl/psm_gap_timer.sv
module psm_gap_timer #(
    parameter int PERIOD = 16,
    parameter int JITTER = 3,
    parameter int GW     = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe,
    output logic [GW-1:0] gap,
    output logic          deadline
);
    localparam logic [GW-1:0] GAP_MAX  = {GW{1'b1}};
    localparam logic [GW-1:0] FIRST_DL = GW'(PERIOD + 2 * JITTER);
    localparam logic [GW-1:0] STEP_DL  = GW'(PERIOD);

    logic [GW-1:0] gap_q;
    logic [GW-1:0] due_q;

    // gap_q holds the edge distance from the last item, as seen at this edge
    assign gap      = gap_q;
    assign deadline = !strobe && (gap_q == due_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GW'(1);
            due_q <= FIRST_DL;
        end else if (strobe) begin
            gap_q <= GW'(1);
            due_q <= FIRST_DL;
        end else begin
            if (gap_q != GAP_MAX) begin
                gap_q <= gap_q + GW'(1);
            end
            if (deadline && (due_q <= GAP_MAX - STEP_DL)) begin
                due_q <= due_q + STEP_DL;
            end
        end
    end

    // R2
    due_floor_chk: assert property (@(posedge clk) disable iff (rst)
        due_q >= FIRST_DL);

    // R3
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> (due_q == FIRST_DL) && !deadline);

endmodule

// File: rtl/psm_spacing_check.sv
module psm_spacing_check #(
    parameter int PERIOD = 16,
    parameter int JITTER = 3,
    parameter int GW     = 7
) (
    input  logic [GW-1:0] gap,
    output logic          in_window
);
    localparam logic [GW-1:0] LOW_EXCL  = GW'(PERIOD - JITTER);
    localparam logic [GW-1:0] HIGH_EXCL = GW'(PERIOD + JITTER);

    always_comb begin
        in_window = (gap > LOW_EXCL) && (gap < HIGH_EXCL);
    end

endmodule

// File: rtl/psm_health_fsm.sv
module psm_health_fsm
    import psm_pkg::*;
#(
    parameter int MISS_LIMIT    = 3,
    parameter int RECOVER_COUNT = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe,
    input  logic   deadline,
    input  logic   in_window,
    output pulse_t pulses,
    output logic   faulty
);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam int RW = $clog2(RECOVER_COUNT + 1);
    localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);
    localparam logic [RW-1:0] RUN_DONE  = RW'(RECOVER_COUNT);

    mode_e         mode_q, mode_n;
    logic [MW-1:0] miss_q, miss_n;
    logic [RW-1:0] run_q,  run_n;
    pulse_t        pulse_q, pulse_n;

    always_comb begin
        mode_n  = mode_q;
        miss_n  = miss_q;
        run_n   = run_q;
        pulse_n = '0;
        unique case (mode_q)
            MODE_HEALTHY: begin
                if (strobe) begin
                    miss_n = '0;
                end else if (deadline) begin
                    if (miss_q == MISS_LAST) begin
                        pulse_n.err = 1'b1;
                        mode_n      = MODE_FAULT;
                        miss_n      = '0;
                        run_n       = '0;
                    end else begin
                        pulse_n.miss = 1'b1;
                        miss_n       = miss_q + MW'(1);
                    end
                end
            end
            MODE_FAULT: begin
                if (strobe) begin
                    if ((run_q == '0) || !in_window) begin
                        run_n = RW'(1);
                    end else begin
                        run_n = run_q + RW'(1);
                    end
                    if (run_n == RUN_DONE) begin
                        pulse_n.ok = 1'b1;
                        mode_n     = MODE_HEALTHY;
                        run_n      = '0;
                        miss_n     = '0;
                    end
                end
            end
            default: mode_n = MODE_HEALTHY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_HEALTHY;
            miss_q  <= '0;
            run_q   <= '0;
            pulse_q <= '0;
        end else begin
            mode_q  <= mode_n;
            miss_q  <= miss_n;
            run_q   <= run_n;
            pulse_q <= pulse_n;
        end
    end

    assign pulses = pulse_q;
    assign faulty = (mode_q == MODE_FAULT);

    // R8
    miss_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pulse_q.miss && pulse_q.err));

    // R5
    miss_healthy_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q.miss |-> !faulty);

    // R4
    err_enters_fault_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(faulty) |-> pulse_q.err);

    // R8
    err_idle_edge_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q.err |-> !$past(strobe));

    // R6
    ok_item_edge_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q.ok |-> $past(strobe) && $past(faulty) && !faulty);

    // R8
    one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_q != '0) |=> (pulse_q == '0));

    // R7
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run_q < RUN_DONE);

endmodule

// File: rtl/periodic_source_monitor.sv
module periodic_source_monitor
    import psm_pkg::*;
#(
    parameter int PERIOD        = 16,
    parameter int JITTER        = 3,
    parameter int MISS_LIMIT    = 3,
    parameter int RECOVER_COUNT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic data_strobe,
    output logic err_pulse,
    output logic ok_pulse,
    output logic miss_pulse,
    output logic in_error
);
    localparam bit CFG_OK = cfg_legal(PERIOD, JITTER, MISS_LIMIT, RECOVER_COUNT);
    localparam int GW     = gap_bits(PERIOD, JITTER, MISS_LIMIT);

    if (!CFG_OK) begin : g_bad_cfg
        initial $fatal(1, "periodic_source_monitor: illegal parameter set");
    end

    logic [GW-1:0] gap;
    logic          deadline;
    logic          in_window;
    pulse_t        pulses;

    psm_gap_timer #(
        .PERIOD (PERIOD),
        .JITTER (JITTER),
        .GW     (GW)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .strobe   (data_strobe),
        .gap      (gap),
        .deadline (deadline)
    );

    psm_spacing_check #(
        .PERIOD (PERIOD),
        .JITTER (JITTER),
        .GW     (GW)
    ) u_spacing (
        .gap       (gap),
        .in_window (in_window)
    );

    psm_health_fsm #(
        .MISS_LIMIT    (MISS_LIMIT),
        .RECOVER_COUNT (RECOVER_COUNT)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .strobe    (data_strobe),
        .deadline  (deadline),
        .in_window (in_window),
        .pulses    (pulses),
        .faulty    (in_error)
    );

    assign err_pulse  = pulses.err;
    assign ok_pulse   = pulses.ok;
    assign miss_pulse = pulses.miss;

endmodule

// File: tb/test_periodic_source_monitor.sv
`timescale 1ns/1ps
module test_periodic_source_monitor;

    localparam int PERIOD = 16;
    localparam int JITTER = 3;
    localparam int KLIM   = 3;
    localparam int NREC   = 2;
    localparam int NVEC   = 16;

    // {edges since previous item, misses, errs, oks, in_error after, req}
    localparam int VEC [NVEC][6] = '{
        '{16,  0, 0, 0, 0, 2},   // R2 on time
        '{16,  0, 0, 0, 0, 2},   // R2 on time
        '{30,  1, 0, 0, 0, 2},   // R2 one miss at 22
        '{60,  2, 1, 0, 1, 4},   // R4 misses 22,38, err 54
        '{16,  0, 0, 1, 0, 6},   // R6 second good item
        '{16,  0, 0, 0, 0, 3},   // R3 healthy again
        '{60,  2, 1, 0, 1, 4},   // R4 again
        '{19,  0, 0, 0, 1, 7},   // R7 spacing P+J rejected
        '{13,  0, 0, 0, 1, 7},   // R7 spacing P-J rejected
        '{14,  0, 0, 1, 0, 6},   // R6 spacing P-J+1 accepted
        '{18,  0, 0, 0, 0, 3},   // R3
        '{22,  0, 0, 0, 0, 3},   // R3 item on deadline edge
        '{23,  1, 0, 0, 0, 2},   // R2 deadline one edge before item
        '{100, 2, 1, 0, 1, 5},   // R5 silent in error, no misses
        '{40,  0, 0, 0, 1, 5},   // R5 long gap, no misses, run restarts
        '{16,  0, 0, 1, 0, 6}    // R6
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic data_strobe = 1'b0;
    logic err_pulse, ok_pulse, miss_pulse, in_error;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    periodic_source_monitor #(
        .PERIOD        (PERIOD),
        .JITTER        (JITTER),
        .MISS_LIMIT    (KLIM),
        .RECOVER_COUNT (NREC)
    ) i_periodic_source_monitor (
        .clk         (clk),
        .rst         (rst),
        .data_strobe (data_strobe),
        .err_pulse   (err_pulse),
        .ok_pulse    (ok_pulse),
        .miss_pulse  (miss_pulse),
        .in_error    (in_error)
    );

    task automatic check(input bit cond, input string req,
                         input int actual, input int expected);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic do_reset();
        data_strobe = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    // d edges: d-1 idle, then one item edge; pulses summed over the gap
    task automatic segment(input int d, input int em, input int ee,
                           input int eo, input int ei, input int req);
        int nm = 0, ne = 0, no = 0;
        for (int i = 1; i <= d; i++) begin
            data_strobe = (i == d);
            @(posedge clk);
            #1;
            nm += int'(miss_pulse);
            ne += int'(err_pulse);
            no += int'(ok_pulse);
        end
        data_strobe = 1'b0;
        checks++;
        if (nm != em || ne != ee || no != eo || int'(in_error) != ei) begin
            errors++;
            $display("FAIL R%0d gap=%0d actual m/e/o/f=%0d/%0d/%0d/%0d expected=%0d/%0d/%0d/%0d",
                     req, d, nm, ne, no, int'(in_error), em, ee, eo, ei);
        end
    endtask

    task automatic idle_edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check({err_pulse, ok_pulse, miss_pulse, in_error} == 4'b0, "R1",
              int'({err_pulse, ok_pulse, miss_pulse, in_error}), 0);

        // R1 R2 first miss on edge 22 after the reset edge, one cycle wide (R8)
        idle_edges(21);
        check(miss_pulse == 1'b0, "R2", int'(miss_pulse), 0);
        idle_edges(1);
        check(miss_pulse == 1'b1, "R1", int'(miss_pulse), 1);
        idle_edges(1);
        check(miss_pulse == 1'b0, "R8", int'(miss_pulse), 0);

        // R4 error on edge 54 exactly, no miss with it
        idle_edges(30);
        check(err_pulse == 1'b0 && in_error == 1'b0, "R4", int'(err_pulse), 0);
        idle_edges(1);
        check(err_pulse == 1'b1 && miss_pulse == 1'b0, "R4",
              int'({err_pulse, miss_pulse}), 2);
        check(in_error == 1'b1, "R4", int'(in_error), 1);
        idle_edges(1);
        check(err_pulse == 1'b0 && in_error == 1'b1, "R8",
              int'({err_pulse, in_error}), 1);

        // R1 reset from error
        do_reset();
        check(in_error == 1'b0 && err_pulse == 1'b0, "R1",
              int'({in_error, err_pulse}), 0);

        for (int v = 0; v < NVEC; v++) begin
            segment(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
        end

        // R6 ok falls back to zero after one cycle
        idle_edges(1);
        check(ok_pulse == 1'b0 && in_error == 1'b0, "R6",
              int'({ok_pulse, in_error}), 0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        #2;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule